// File: doc/BRIEF.md
# Temperature-Scaled Refresh Scheduler

This block decides when a DRAM controller must spend time on refresh and holds ordinary traffic off while that refresh is running. It keeps an interval counter whose reload value depends on the refresh granularity and on the die temperature. When the counter runs out, the block raises a request toward the command sequencer. Once the sequencer grants the slot, the block raises a traffic-hold output for the length of the refresh and then starts the next interval.

Three auto-refresh granularities are supported. At the coarsest setting each command covers the full slice. The two finer settings issue commands twice or four times as often, with a shorter hold each. The temperature input is a code in whole degrees Celsius. For every complete 10-degree step at or above 95 degrees the interval is halved, up to four halvings. The per-granularity base intervals are chosen so that every row is refreshed once per 64 ms retention period at normal temperature.

A fourth mode refreshes one row at a time. The sequencer opens the row named on the row-address output and closes it again when the close strobe fires. The block looks up each row in an external live-data mask. A row flagged as holding no live data is stepped over without a request.

Top module: `rfsh_sched`

## Requirements
- R1: While reset is held and in the first cycle after it, `refReq`, `blockTraffic` and `prePulse` are 0 and `rowAddr` is 0.
- R2: With `modeSel` = 2'b00 (coarse) and `tempCode` below 95, `refReq` rises exactly BASE_INTERVAL+1 cycles after `blockTraffic` falls. The extra cycle is the reload cycle.
- R3: `modeSel` = 2'b01 halves the interval and `modeSel` = 2'b10 quarters it. The hold lengths are TRFC_2X and TRFC_4X cycles, against TRFC_1X for the coarse setting.
- R4: The number of temperature steps is floor((tempCode-85)/10) when tempCode >= 95, and 0 below 95. It is clamped to 4. The interval is right-shifted by the granularity shift plus the step count, and is never less than 1 cycle.
- R5: `blockTraffic` rises only in the cycle after `refReq` and `refGnt` are both high. It stays high for exactly the hold length of the granted refresh.
- R6: Once raised, `refReq` stays high until granted, and `blockTraffic` stays low during the wait.
- R7: With `modeSel` = 2'b11 (row mode), the request carries `refRow` = 1 and the interval base is ROW_BASE. The hold lasts ROW_HOLD cycles, and `prePulse` is high for exactly one cycle, the last hold cycle. `rowAddr` then advances by one and wraps after NUM_ROWS-1.
- R8: In row mode, a row whose `rowAlive` bit reads 0 when its interval expires gets no request. `rowAddr` advances and a new interval starts, so one skipped row costs one extra interval+1 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tempCode | input | 8 | Temperature in degrees Celsius, unsigned |
| modeSel | input | 2 | 00 coarse, 01 half, 10 quarter, 11 row-by-row |
| rowAlive | input | 1 | Live-data flag for the row on `rowAddr` |
| refGnt | input | 1 | Sequencer grants the pending refresh |
| rowAddr | output | ROW_W | Current row of the row-by-row counter (mask lookup address) |
| refReq | output | 1 | Refresh slot requested |
| refRow | output | 1 | Pending request is a row open/close, not an auto-refresh |
| blockTraffic | output | 1 | Normal accesses must be held off |
| prePulse | output | 1 | Close the open row now (row mode, last hold cycle) |

## Verification
A table of mode and temperature pairs is applied, and for each pair the hold length and the gap to the next request are measured. The table includes 94, 95, 105, 125 and 200 degrees, which separate an off-by-one step boundary, a missing clamp, and a missing one-cycle floor from correct scaling. The granularity entries show whether the hold value follows the mode and whether the interval shift does. In row mode, a sparse live mask shows whether dead rows are skipped in order, with the right wrap and a one-interval cost per skip. An all-dead mask shows that no request escapes. A delayed grant shows that the request holds and that traffic stays free until the grant.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  typedef enum logic [1:0] {
    GRAN_1X  = 2'b00,
    GRAN_2X  = 2'b01,
    GRAN_4X  = 2'b10,
    GRAN_ROW = 2'b11
  } refMode_e;

  typedef enum logic [1:0] {
    ST_LOAD,
    ST_IDLE,
    ST_REQ,
    ST_BUSY
  } refState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic loadInterval;
    logic loadHold;
    logic holdRow;
    logic advanceRow;
  } dpStrobe_t;

endpackage

// File: rtl/rfsh_dp.sv
module rfsh_dp
  import rfsh_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter int BASE_INTERVAL = 64,
  parameter int ROW_BASE      = 32,
  parameter int TRFC_1X       = 12,
  parameter int TRFC_2X       = 8,
  parameter int TRFC_4X       = 5,
  parameter int ROW_HOLD      = 4,
  parameter int NUM_ROWS      = 8,
  parameter int HOT_C         = 85,
  parameter int STEP_C        = 10,
  parameter int MAX_STEPS     = 4,
  localparam int ROW_W        = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dpStrobe_t        strobe,
  input  logic [1:0]       modeSel,
  input  logic [7:0]       tempCode,
  output logic             intervalDone,
  output logic             holdDone,
  output logic [ROW_W-1:0] rowAddr
);

  localparam logic [7:0] FIRST_HOT = 8'(HOT_C + STEP_C);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(NUM_ROWS - 1);

  logic [CNT_W-1:0] intervalCnt;
  logic [CNT_W-1:0] holdCnt;
  logic [3:0]       tempSteps;
  logic [3:0]       granShift;
  logic [CNT_W-1:0] baseSel;
  logic [CNT_W-1:0] shifted;
  logic [CNT_W-1:0] nextInterval;
  logic [CNT_W-1:0] holdVal;
  logic [7:0]       overTemp;
  logic [7:0]       stepRaw;

  // temperature step count, clamped
  always_comb begin
    overTemp = tempCode - 8'(HOT_C);
    stepRaw  = overTemp / 8'(STEP_C);
    if (tempCode < FIRST_HOT)
      tempSteps = 4'd0;
    else if (stepRaw > 8'(MAX_STEPS))
      tempSteps = 4'(MAX_STEPS);
    else
      tempSteps = stepRaw[3:0];
  end

  always_comb begin
    unique case (refMode_e'(modeSel))
      GRAN_2X:  granShift = 4'd1;
      GRAN_4X:  granShift = 4'd2;
      default:  granShift = 4'd0;
    endcase
    baseSel      = (refMode_e'(modeSel) == GRAN_ROW) ? CNT_W'(ROW_BASE) : CNT_W'(BASE_INTERVAL);
    shifted      = baseSel >> (granShift + tempSteps);
    nextInterval = (shifted == '0) ? CNT_W'(1) : shifted;
  end

  always_comb begin
    if (strobe.holdRow)
      holdVal = CNT_W'(ROW_HOLD);
    else begin
      unique case (refMode_e'(modeSel))
        GRAN_2X: holdVal = CNT_W'(TRFC_2X);
        GRAN_4X: holdVal = CNT_W'(TRFC_4X);
        default: holdVal = CNT_W'(TRFC_1X);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      intervalCnt <= '0;
    else if (strobe.loadInterval)
      intervalCnt <= nextInterval - CNT_W'(1);
    else if (intervalCnt != '0)
      intervalCnt <= intervalCnt - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      holdCnt <= '0;
    else if (strobe.loadHold)
      holdCnt <= holdVal - CNT_W'(1);
    else if (holdCnt != '0)
      holdCnt <= holdCnt - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rowAddr <= '0;
    else if (strobe.advanceRow)
      rowAddr <= (rowAddr == LAST_ROW) ? '0 : rowAddr + ROW_W'(1);
  end

  assign intervalDone = (intervalCnt == '0);
  assign holdDone     = (holdCnt == '0);

endmodule

// File: rtl/rfsh_ctrl.sv
module rfsh_ctrl
  import rfsh_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rowMode,
  input  logic      rowAlive,
  input  logic      refGnt,
  input  logic      intervalDone,
  input  logic      holdDone,
  output dpStrobe_t strobe,
  output logic      refReq,
  output logic      refRow,
  output logic      blockTraffic,
  output logic      prePulse
);

  refState_e state, stateNext;
  logic      rowKind, rowKindNext;

  always_comb begin
    stateNext   = state;
    rowKindNext = rowKind;
    strobe      = '0;
    unique case (state)
      ST_LOAD: begin
        strobe.loadInterval = 1'b1;
        stateNext           = ST_IDLE;
      end
      ST_IDLE: begin
        if (intervalDone) begin
          if (rowMode && !rowAlive) begin
            strobe.advanceRow = 1'b1;
            stateNext         = ST_LOAD;
          end else begin
            rowKindNext = rowMode;
            stateNext   = ST_REQ;
          end
        end
      end
      ST_REQ: begin
        if (refGnt) begin
          strobe.loadHold = 1'b1;
          stateNext       = ST_BUSY;
        end
      end
      ST_BUSY: begin
        if (holdDone) begin
          strobe.advanceRow = rowKind;
          stateNext         = ST_LOAD;
        end
      end
      default: stateNext = ST_LOAD;
    endcase
    strobe.holdRow = rowKind;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_LOAD;
      rowKind <= 1'b0;
    end else begin
      state   <= stateNext;
      rowKind <= rowKindNext;
    end
  end

  assign refReq       = (state == ST_REQ);
  assign refRow       = (state == ST_REQ) && rowKind;
  assign blockTraffic = (state == ST_BUSY);
  assign prePulse     = (state == ST_BUSY) && holdDone && rowKind;

endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched
  import rfsh_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter int BASE_INTERVAL = 64,
  parameter int ROW_BASE      = 32,
  parameter int TRFC_1X       = 12,
  parameter int TRFC_2X       = 8,
  parameter int TRFC_4X       = 5,
  parameter int ROW_HOLD      = 4,
  parameter int NUM_ROWS      = 8,
  localparam int ROW_W        = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       tempCode,
  input  logic [1:0]       modeSel,
  input  logic             rowAlive,
  input  logic             refGnt,
  output logic [ROW_W-1:0] rowAddr,
  output logic             refReq,
  output logic             refRow,
  output logic             blockTraffic,
  output logic             prePulse
);

  dpStrobe_t strobe;
  logic      intervalDone;
  logic      holdDone;

  rfsh_ctrl ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .rowMode      (refMode_e'(modeSel) == GRAN_ROW),
    .rowAlive     (rowAlive),
    .refGnt       (refGnt),
    .intervalDone (intervalDone),
    .holdDone     (holdDone),
    .strobe       (strobe),
    .refReq       (refReq),
    .refRow       (refRow),
    .blockTraffic (blockTraffic),
    .prePulse     (prePulse)
  );

  rfsh_dp #(
    .CNT_W         (CNT_W),
    .BASE_INTERVAL (BASE_INTERVAL),
    .ROW_BASE      (ROW_BASE),
    .TRFC_1X       (TRFC_1X),
    .TRFC_2X       (TRFC_2X),
    .TRFC_4X       (TRFC_4X),
    .ROW_HOLD      (ROW_HOLD),
    .NUM_ROWS      (NUM_ROWS)
  ) dp_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe       (strobe),
    .modeSel      (modeSel),
    .tempCode     (tempCode),
    .intervalDone (intervalDone),
    .holdDone     (holdDone),
    .rowAddr      (rowAddr)
  );

endmodule

// File: rtl/rfsh_sched_chk.sv
module rfsh_sched_chk #(
  parameter int ROW_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rowAlive,
  input logic             refGnt,
  input logic [ROW_W-1:0] rowAddr,
  input logic             refReq,
  input logic             refRow,
  input logic             blockTraffic,
  input logic             prePulse
);

  // R5: hold starts only after a granted request
  a_r5_block_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blockTraffic) |-> $past(refReq && refGnt));

  // R6: request persists until granted
  a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (refReq && !refGnt) |=> refReq);

  // R6: traffic free while waiting
  a_r6_no_block_wait: assert property (@(posedge clk) disable iff (!rst_n)
    refReq |-> !blockTraffic);

  // R7: close strobe is the last hold cycle
  a_r7_pre_last: assert property (@(posedge clk) disable iff (!rst_n)
    prePulse |-> blockTraffic ##1 !blockTraffic);

  // R7: row address frozen during a hold
  a_r7_row_stable: assert property (@(posedge clk) disable iff (!rst_n)
    blockTraffic |-> $stable(rowAddr));

  // R7: row-kind flag only accompanies a request
  a_r7_kind_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    refRow |-> refReq);

  // R8: row moves only after a hold or on a dead row
  a_r8_skip_only_dead: assert property (@(posedge clk) disable iff (!rst_n)
    (rowAddr != $past(rowAddr)) |-> ($past(blockTraffic) || !$past(rowAlive)));

endmodule

bind rfsh_sched rfsh_sched_chk #(.ROW_W(ROW_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .rowAlive     (rowAlive),
  .refGnt       (refGnt),
  .rowAddr      (rowAddr),
  .refReq       (refReq),
  .refRow       (refRow),
  .blockTraffic (blockTraffic),
  .prePulse     (prePulse)
);

// File: tb/rfsh_sched_tb.sv
module rfsh_sched_tb_top;

  localparam int NUM_ROWS = 8;
  localparam int ROW_W    = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [7:0]       tempCode = 8'd25;
  logic [1:0]       modeSel = 2'b00;
  logic             refGnt = 1'b0;
  logic [7:0]       aliveMask = 8'hFF;
  logic             rowAlive;
  logic [ROW_W-1:0] rowAddr;
  logic             refReq, refRow, blockTraffic, prePulse;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 0;

  always #5 clk = ~clk;

  assign rowAlive = aliveMask[rowAddr];

  rfsh_sched dut_i (
    .clk (clk), .rst_n (rst_n), .tempCode (tempCode), .modeSel (modeSel),
    .rowAlive (rowAlive), .refGnt (refGnt), .rowAddr (rowAddr),
    .refReq (refReq), .refRow (refRow), .blockTraffic (blockTraffic),
    .prePulse (prePulse)
  );

  // {mode, temp, expected interval, expected hold}
  typedef struct packed {
    logic [1:0] mode;
    logic [7:0] temp;
    int         expI;
    int         expH;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 8'd25,  64, 12},   // R2
    '{2'b01, 8'd25,  32, 8},    // R3
    '{2'b10, 8'd25,  16, 5},    // R3
    '{2'b00, 8'd94,  64, 12},   // R4 below first step
    '{2'b00, 8'd95,  32, 12},   // R4 first step
    '{2'b00, 8'd105, 16, 12},   // R4
    '{2'b01, 8'd115, 4,  8},    // R4
    '{2'b00, 8'd125, 4,  12},   // R4 clamp reached
    '{2'b10, 8'd200, 1,  5},    // R4 clamp and floor
    '{2'b11, 8'd25,  32, 4},    // R7
    '{2'b11, 8'd105, 8,  4}     // R7 with R4
  };

  task automatic chk(input string req, input int act, input int exp);
    checkCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitReq();
    while (!refReq) @(negedge clk);
  endtask

  // grant pending request, return hold length and close-strobe count
  task automatic grantAndHold(output int hold, output int pres, output int preLast);
    refGnt = 1'b1;
    @(negedge clk);
    refGnt  = 1'b0;
    hold    = 0;
    pres    = 0;
    preLast = 0;
    while (blockTraffic) begin
      hold++;
      if (prePulse) begin
        pres++;
        preLast = hold;
      end
      @(negedge clk);
    end
  endtask

  task automatic gapToReq(output int gap);
    gap = 0;
    while (!refReq) begin
      @(negedge clk);
      gap++;
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    int h, p, pl, g, waitBad;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: state during reset
    chk("R1 refReq in reset", int'(refReq), 0);
    chk("R1 blockTraffic in reset", int'(blockTraffic), 0);
    chk("R1 rowAddr in reset", int'(rowAddr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 outputs after reset", int'({refReq, blockTraffic, prePulse}), 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      modeSel  = VECS[i].mode;
      tempCode = VECS[i].temp;
      waitReq();
      grantAndHold(h, p, pl);   // warm-up refresh
      gapToReq(g);
      grantAndHold(h, p, pl);
      chk($sformatf("R5 hold vec%0d", i), h, VECS[i].expH);
      if (VECS[i].mode == 2'b11) begin
        chk($sformatf("R7 prePulse count vec%0d", i), p, 1);
        chk($sformatf("R7 prePulse on last hold cycle vec%0d", i), pl, h);
      end
      gapToReq(g);
      chk($sformatf("R2 R3 R4 interval vec%0d mode%0d temp%0d", i, VECS[i].mode, VECS[i].temp),
          g, VECS[i].expI + 1);
    end

    // R6: delayed grant
    modeSel  = 2'b00;
    tempCode = 8'd25;
    waitReq();
    grantAndHold(h, p, pl);
    waitReq();
    waitBad = 0;
    for (int k = 0; k < 5; k++) begin
      if (!refReq || blockTraffic) waitBad++;
      @(negedge clk);
    end
    chk("R6 request held and traffic free while waiting", waitBad, 0);
    grantAndHold(h, p, pl);
    chk("R6 R5 hold after late grant", h, 12);

    // R8: sparse live mask, rows 0,2,4,5,7 alive
    modeSel   = 2'b11;
    tempCode  = 8'd25;
    aliveMask = 8'hB5;
    doReset();
    begin
      int rowsExp [6] = '{0, 2, 4, 5, 7, 0};
      int gapsExp [5] = '{66, 66, 33, 66, 33};
      waitReq();
      chk("R8 first row", int'(rowAddr), 0);
      chk("R7 refRow flag", int'(refRow), 1);
      for (int r = 1; r < 6; r++) begin
        grantAndHold(h, p, pl);
        gapToReq(g);
        chk($sformatf("R8 gap before row %0d", rowsExp[r]), g, gapsExp[r-1]);
        chk($sformatf("R8 row order step %0d", r), int'(rowAddr), rowsExp[r]);
      end
      grantAndHold(h, p, pl);
    end

    // R8: all rows dead, no request at all
    aliveMask = 8'h00;
    doReset();
    waitBad = 0;
    for (int k = 0; k < 400; k++) begin
      if (refReq || blockTraffic) waitBad++;
      @(negedge clk);
    end
    chk("R8 no request with all rows dead", waitBad, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failCnt++;
      checkCnt++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

endmodule